// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

A combinational datapath slice that pulls fields out of a 32-bit word and puts them back in. It can extract a field zero-extended or sign-extended, insert a field into an existing word, pull out a single bit, and sign-extend a word from a chosen bit position. A field is described by one 10-bit descriptor that packs a starting bit index and a width minus one. Single-bit and sign-extend operations use the low five descriptor bits as a bit index.

The caller supplies the source word, the descriptor, the previous value of the destination, an operation code and a legacy-mode input. The unit returns the new destination value. It also returns sign and zero flag values, each with its own write enable. The register file and instruction decode sit outside the block. A flag whose enable is low is driven to 0.

Top module: `bitfield_unit`

## Requirements
- R1: `field_desc[4:0]` is the field's lowest bit index `lo` and `field_desc[9:5]` is the field width minus one `wm1`. `op_sel` encodes 0 unsigned extract, 1 signed extract, 2 insert, 3 single-bit extract, 4 sign-extend.
- R2: Unsigned extract returns source bits `lo..lo+wm1` right-aligned, with every higher result bit 0. Source bits above bit 31 read as 0.
- R3: Signed extract returns the same field, but fills every result bit above `wm1` with source bit `(lo + wm1) mod 32`.
- R4: Both extracts assert both flag enables. The zero flag is set exactly when the result is 0. The sign flag equals the fill bit, so it is always 0 for unsigned extract.
- R5: Insert with `lo + wm1 + 1 <= 32` returns `dst_prev` with bits `lo..lo+wm1` replaced by source bits `0..wm1`.
- R6: Insert with `lo + wm1 + 1 > 32` returns `dst_prev` unchanged.
- R7: Insert deasserts both flag enables and drives both flag values to 0.
- R8: A descriptor with `lo = 0` and `wm1 = 31` extracts the whole source word, unchanged for both extract kinds.
- R9: Sign-extend keeps source bits `0..idx` (idx = `field_desc[4:0]`) and copies source bit `idx` into all higher bits. It sets sign from result bit 31 and zero from the result, with both enables high.
- R10: Single-bit extract with `legacy_mode` low returns source bit `idx` in bit 0 with all other bits 0. It sets the sign flag to 0, sets the zero flag when that bit is 0, and asserts both enables.
- R11: Single-bit extract with `legacy_mode` high returns `dst_prev` with only bit 0 replaced by source bit `idx`. It asserts no flag enable.
- R12: Op codes 5 to 7 return `dst_prev` with both flag enables low and both flag values 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_word | input | 32 | Source word |
| field_desc | input | 10 | Field descriptor, or bit index in bits 4:0 |
| dst_prev | input | 32 | Previous destination value |
| op_sel | input | 3 | Operation code |
| legacy_mode | input | 1 | Selects legacy single-bit extract behaviour |
| result | output | 32 | New destination value |
| flag_sign | output | 1 | Sign flag value |
| flag_zero | output | 1 | Zero flag value |
| sign_we | output | 1 | Sign flag write enable |
| zero_we | output | 1 | Zero flag write enable |

## Verification
The bench aims at the full-width descriptor, where a mask built as `(1 << 32) - 1` would collapse to zero and return nothing. It also targets a signed extract whose sign position wraps past bit 31; a design that saturated the index instead of wrapping would pick the wrong fill bit. Inserts that end exactly at bit 31, and inserts one bit past it, test the range check: an off-by-one there either corrupts `dst_prev` or wrongly refuses a legal insert. The legacy single-bit path is checked for keeping the upper 31 destination bits and for writing no flags, where a shared path would clear them.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    BF_EXTU = 3'd0,
    BF_EXTS = 3'd1,
    BF_INS  = 3'd2,
    BF_XBIT = 3'd3,
    BF_SEXT = 3'd4
  } bf_op_e;
endpackage

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int W  = bfu_pkg::WORD_W,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  logic [IW-1:0] lo,
  input  logic [IW-1:0] wm1,
  input  logic          signed_mode,
  output logic [W-1:0]  value,
  output logic          fill
);
  // ones in bits 0..top, never needs a shift by W
  function automatic logic [W-1:0] ones_upto(input logic [IW-1:0] top);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i <= int'(top));
    return m;
  endfunction

  logic [W-1:0]  keep;
  logic [IW-1:0] fill_idx;

  always_comb begin
    keep     = ones_upto(wm1);
    fill_idx = lo + wm1;               // wraps modulo W
    fill     = signed_mode & src[fill_idx];
    value    = ((src >> lo) & keep) | ({W{fill}} & ~keep);
  end
endmodule

// File: rtl/bfu_insert.sv
module bfu_insert #(
  parameter int W  = bfu_pkg::WORD_W,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  dst,
  input  logic [W-1:0]  src,
  input  logic [IW-1:0] lo,
  input  logic [IW-1:0] wm1,
  output logic [W-1:0]  value,
  output logic          in_range
);
  localparam logic [IW:0] SPAN_MAX = (IW+1)'(W);

  function automatic logic [W-1:0] ones_upto(input logic [IW-1:0] top);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i <= int'(top));
    return m;
  endfunction

  logic [IW:0]  span;
  logic [W-1:0] field;

  always_comb begin
    span     = {1'b0, lo} + {1'b0, wm1} + {{IW{1'b0}}, 1'b1};
    in_range = (span <= SPAN_MAX);
    field    = ones_upto(wm1) << lo;
    value    = in_range ? ((dst & ~field) | ((src << lo) & field)) : dst;
  end
endmodule

// File: rtl/bfu_sext.sv
module bfu_sext #(
  parameter int W  = bfu_pkg::WORD_W,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  value,
  output logic          picked
);
  always_comb begin
    picked = src[idx];
    for (int i = 0; i < W; i++)
      value[i] = (i <= int'(idx)) ? src[i] : picked;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int W  = bfu_pkg::WORD_W,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]    src_word,
  input  logic [2*IW-1:0] field_desc,
  input  logic [W-1:0]    dst_prev,
  input  logic [2:0]      op_sel,
  input  logic            legacy_mode,
  output logic [W-1:0]    result,
  output logic            flag_sign,
  output logic            flag_zero,
  output logic            sign_we,
  output logic            zero_we
);
  import bfu_pkg::*;

  logic [IW-1:0] desc_lo, desc_wm1;
  logic [W-1:0]  ext_value, ins_value, sext_value;
  logic          ext_fill, ins_in_range, bit_picked;

  assign desc_lo  = field_desc[IW-1:0];
  assign desc_wm1 = field_desc[2*IW-1:IW];

  bfu_extract #(.W(W)) u_extract (
    .src(src_word), .lo(desc_lo), .wm1(desc_wm1),
    .signed_mode(op_sel == BF_EXTS), .value(ext_value), .fill(ext_fill)
  );

  bfu_insert #(.W(W)) u_insert (
    .dst(dst_prev), .src(src_word), .lo(desc_lo), .wm1(desc_wm1),
    .value(ins_value), .in_range(ins_in_range)
  );

  bfu_sext #(.W(W)) u_sext (
    .src(src_word), .idx(desc_lo), .value(sext_value), .picked(bit_picked)
  );

  always_comb begin
    result    = dst_prev;
    flag_sign = 1'b0;
    flag_zero = 1'b0;
    sign_we   = 1'b0;
    zero_we   = 1'b0;
    case (op_sel)
      BF_EXTU, BF_EXTS: begin
        result    = ext_value;
        flag_sign = ext_fill;
        flag_zero = (ext_value == '0);
        sign_we   = 1'b1;
        zero_we   = 1'b1;
      end
      BF_INS: result = ins_value;
      BF_XBIT: begin
        if (legacy_mode) begin
          result = {dst_prev[W-1:1], bit_picked};
        end else begin
          result    = {{(W-1){1'b0}}, bit_picked};
          flag_zero = ~bit_picked;
          sign_we   = 1'b1;
          zero_we   = 1'b1;
        end
      end
      BF_SEXT: begin
        result    = sext_value;
        flag_sign = sext_value[W-1];
        flag_zero = (sext_value == '0);
        sign_we   = 1'b1;
        zero_we   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
  parameter int W  = bfu_pkg::WORD_W,
  localparam int IW = $clog2(W)
) (
  input logic [W-1:0]    src_word,
  input logic [2*IW-1:0] field_desc,
  input logic [W-1:0]    dst_prev,
  input logic [2:0]      op_sel,
  input logic            legacy_mode,
  input logic [W-1:0]    result,
  input logic            flag_sign,
  input logic            flag_zero,
  input logic            sign_we,
  input logic            zero_we,
  input logic            ins_in_range,
  input logic            ext_fill
);
  import bfu_pkg::*;

  always_comb begin
    if (zero_we === 1'b1)
      AST_ZERO_MATCHES: assert (flag_zero == (result == '0)) else $error("zero flag"); // R4
    if (op_sel == BF_EXTU)
      AST_EXTU_SIGN_LOW: assert (!flag_sign && !ext_fill) else $error("extu sign"); // R4
    if (op_sel == BF_INS)
      AST_INS_NO_FLAGS: assert (!sign_we && !zero_we && !flag_sign && !flag_zero) else $error("ins flags"); // R7
    if (op_sel == BF_INS && ins_in_range === 1'b0)
      AST_INS_OOR_KEEP: assert (result == dst_prev) else $error("ins oor"); // R6
    if (op_sel == BF_XBIT && legacy_mode === 1'b1)
      AST_LEGACY_UPPER: assert (result[W-1:1] == dst_prev[W-1:1] && !sign_we && !zero_we) else $error("legacy"); // R11
    if (op_sel == BF_XBIT && legacy_mode === 1'b0)
      AST_XBIT_NARROW: assert (result[W-1:1] == '0 && !flag_sign && result[0] == src_word[field_desc[IW-1:0]]) else $error("xbit"); // R10
    if (op_sel == BF_SEXT)
      AST_SEXT_SIGN: assert (flag_sign == result[W-1]) else $error("sext sign"); // R9
    if (op_sel inside {3'd5, 3'd6, 3'd7})
      AST_RESERVED_HOLD: assert (result == dst_prev && !sign_we && !zero_we) else $error("reserved"); // R12
  end
endmodule

bind bitfield_unit bfu_checker #(.W(W)) i_chk (
  .src_word(src_word), .field_desc(field_desc), .dst_prev(dst_prev),
  .op_sel(op_sel), .legacy_mode(legacy_mode), .result(result),
  .flag_sign(flag_sign), .flag_zero(flag_zero), .sign_we(sign_we),
  .zero_we(zero_we), .ins_in_range(ins_in_range), .ext_fill(ext_fill)
);

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;
  logic        clk = 1'b0;
  logic [31:0] src_word = '0;
  logic [9:0]  field_desc = '0;
  logic [31:0] dst_prev = '0;
  logic [2:0]  op_sel = 3'd0;
  logic        legacy_mode = 1'b0;
  logic [31:0] result;
  logic        flag_sign, flag_zero, sign_we, zero_we;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  bitfield_unit i_bitfield_unit (
    .src_word(src_word), .field_desc(field_desc), .dst_prev(dst_prev),
    .op_sel(op_sel), .legacy_mode(legacy_mode), .result(result),
    .flag_sign(flag_sign), .flag_zero(flag_zero), .sign_we(sign_we),
    .zero_we(zero_we)
  );

  // returns {result, sign, zero, sign_we, zero_we}
  function automatic logic [35:0] model(input logic [2:0] op, input logic [31:0] s,
                                        input logic [9:0] d, input logic [31:0] p,
                                        input logic lg);
    int lo = int'(d[4:0]);
    int wm = int'(d[9:5]);
    logic [63:0] m64 = (64'd1 << (wm + 1)) - 64'd1;
    logic [31:0] m = m64[31:0];
    logic [63:0] wide = {32'd0, s} >> lo;
    logic [31:0] r;
    logic fl;
    logic signed [31:0] t;
    case (op)
      3'd0, 3'd1: begin
        fl = (op == 3'd1) ? s[(lo + wm) % 32] : 1'b0;
        r = (wide[31:0] & m) | (fl ? ~m : 32'd0);
        return {r, fl, r == 32'd0, 2'b11};
      end
      3'd2: begin
        if (lo + wm + 1 <= 32) begin
          logic [63:0] f = m64 << lo;
          logic [63:0] sv = {32'd0, s} << lo;
          r = (p & ~f[31:0]) | (sv[31:0] & f[31:0]);
        end else r = p;
        return {r, 4'b0000};
      end
      3'd3: begin
        if (lg) return {p[31:1], s[lo], 4'b0000};
        return {31'd0, s[lo], 1'b0, !s[lo], 2'b11};
      end
      3'd4: begin
        t = s << (31 - lo);
        r = t >>> (31 - lo);
        return {r, r[31], r == 32'd0, 2'b11};
      end
      default: return {p, 4'b0000};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [9:0] d,
                                   input logic lg, input bit flags);
    case (op)
      3'd0: return flags ? "R4" : "R2";
      3'd1: return flags ? "R4" : "R3";
      3'd2: return flags ? "R7" : ((int'(d[4:0]) + int'(d[9:5]) + 1 <= 32) ? "R5" : "R6");
      3'd3: return lg ? "R11" : "R10";
      3'd4: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [31:0] s, input logic [9:0] d,
                       input logic [31:0] p, input logic lg, input string tag);
    logic [35:0] exp;
    string tr, tf;
    @(negedge clk);
    op_sel = op; src_word = s; field_desc = d; dst_prev = p; legacy_mode = lg;
    #5;
    exp = model(op, s, d, p, lg);
    tr = (tag != "") ? tag : tag_of(op, d, lg, 0);
    tf = (tag != "") ? tag : tag_of(op, d, lg, 1);
    checks++;
    if (result !== exp[35:4]) begin
      errors++;
      $display("FAIL %s result op=%0d desc=%h got %h expected %h", tr, op, d, result, exp[35:4]);
    end
    checks++;
    if ({flag_sign, flag_zero, sign_we, zero_we} !== exp[3:0]) begin
      errors++;
      $display("FAIL %s flags op=%0d desc=%h got %b expected %b", tf, op, d,
               {flag_sign, flag_zero, sign_we, zero_we}, exp[3:0]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    // initial state: all-zero inputs, unsigned extract of 0
    #5;
    checks++;
    if (result !== 32'd0 || flag_zero !== 1'b1 || flag_sign !== 1'b0) begin
      errors++;
      $display("FAIL R4 initial got %h/%b expected 00000000/1", result, flag_zero);
    end
    // R1 descriptor packing: lo=8, wm1=3 -> nibble at bits 11:8
    apply(3'd0, 32'h0000_0A00, {5'd3, 5'd8}, 32'h0, 1'b0, "R1");
    // R8 full width, both extract kinds
    apply(3'd0, 32'hDEAD_BEEF, {5'd31, 5'd0}, 32'h0, 1'b0, "R8");
    apply(3'd1, 32'hDEAD_BEEF, {5'd31, 5'd0}, 32'h0, 1'b0, "R8");
    // R3 sign position wraps past bit 31: lo=30, wm1=5 -> bit 3
    apply(3'd1, 32'h0000_0008, {5'd5, 5'd30}, 32'h0, 1'b0, "R3");
    apply(3'd1, 32'hFFFF_FFF7, {5'd5, 5'd30}, 32'h0, 1'b0, "R3");
    // R5 insert ending exactly at bit 31, R6 one past
    apply(3'd2, 32'h0000_000F, {5'd3, 5'd28}, 32'h1234_5678, 1'b0, "R5");
    apply(3'd2, 32'h0000_000F, {5'd4, 5'd28}, 32'h1234_5678, 1'b0, "R6");
    apply(3'd2, 32'hFFFF_FFFF, {5'd31, 5'd1}, 32'hCAFE_F00D, 1'b0, "R6");
    // R9 sign extend at bit 31 and bit 0
    apply(3'd4, 32'h8000_0000, {5'd0, 5'd31}, 32'h0, 1'b0, "R9");
    apply(3'd4, 32'h0000_0001, {5'd0, 5'd0}, 32'h0, 1'b0, "R9");
    // R10 / R11 single bit
    apply(3'd3, 32'h8000_0000, {5'd0, 5'd31}, 32'hFFFF_FFFE, 1'b0, "R10");
    apply(3'd3, 32'h8000_0000, {5'd0, 5'd30}, 32'hFFFF_FFFF, 1'b1, "R11");
    // R12 reserved codes
    apply(3'd5, 32'h1, 10'h3FF, 32'hA5A5_5A5A, 1'b0, "R12");
    apply(3'd7, 32'h1, 10'h000, 32'h0000_0000, 1'b1, "R12");
    for (int n = 0; n < 3000; n++)
      apply(3'($urandom_range(0, 7)), $urandom, 10'($urandom), $urandom,
            1'($urandom), "");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule